// File: doc/BRIEF.md
# Processor Presence Map Register Block

This block keeps a bitmap of which processors are present, one bit for each processor number, inside a 32-byte I/O window. At reset the map is loaded from a parameter that lists the processors present at start. A plug port carries a processor number and a strobe. Each valid plug sets the matching bit and then sends out a one-cycle hotplug status event, which a downstream interrupt block consumes.

Software reads the map through a byte-addressed bus port. An access can be 1, 2, 3 or 4 bytes wide. Inside the block each access is split into independent byte lanes. To software the map is read-only, with one exception. A write that carries the byte value zero to offset 0 means "leave legacy mode". A plug whose number lies past the end of the map raises the same request. The request is a level output that stays high until reset. While it is high, the block ignores plug requests.

Top module: `cpu_presence_regs`

## Requirements
- R1: Reset state. After reset the map equals `INIT_MAP`, with processor n at bit n of the vector. `legacy_exit`, `hp_event` and `bus_rvalid` are all 0.
- R2: A plug in cycle T sets map bit `plug_id mod 8` of byte `plug_id / 8`, provided `plug_id / 8` is below 32 and `legacy_exit` is 0. A read issued in cycle T+1 sees the bit. No bit of the map is ever cleared except by reset.
- R3: Each accepted plug raises `hp_event` for exactly one cycle, in cycle T+2. This is the cycle after the bit becomes readable. Re-plugging a bit that is already set still raises the event.
- R4: A read in cycle T (`bus_req`=1, `bus_we`=0) gives `bus_rvalid`=1 in cycle T+1. `bus_rdata[8k+7:8k]` holds map byte `bus_addr+k` (little-endian) for each lane k ≤ `bus_size`, where `bus_size` is the byte count minus 1. Lanes above the size read 0. Lanes whose offset is 32 or more read 0. Writes give no `bus_rvalid`.
- R5: A write whose lane at offset 0 carries data 0x00 sets `legacy_exit` in the next cycle. This covers a 1-byte write of 0x00 to address 0, and any wider write to address 0 whose low byte is 0x00.
- R6: Every other write leaves the map and `legacy_exit` unchanged. Examples are nonzero data at offset 0, or zero data at any other offset.
- R7: A plug with `plug_id / 8` of 32 or more leaves the map alone and raises no event. It sets `legacy_exit` in the next cycle.
- R8: `legacy_exit` stays 1 until reset. While it is 1, plugs change no map bit and raise no event. Reads still work.
- R9: When a plug and a read of the same byte fall in one cycle, the read returns the byte as it was before the plug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plug_valid | input | 1 | Plug strobe, one cycle per request |
| plug_id | input | PLUG_ID_W | Processor number of the plug request |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(MAP_BYTES) | Byte offset of lane 0 |
| bus_size | input | 2 | Access size in bytes minus 1 |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data, little-endian lanes |
| legacy_exit | output | 1 | Sticky request to leave legacy mode |
| hp_event | output | 1 | One-cycle hotplug status event |

## Verification
A plug and a bus read can hit the same map byte in the same cycle. The bench provokes this by driving processor 9 together with a 1-byte read of offset 1. It expects the read to return the byte without bit 1, and a second read to return it with bit 1 set.

The bench also sweeps all 256 processor numbers in a scattered order. It sweeps every offset with every access size against an arithmetic model of the map. It checks that both ways of leaving legacy mode take effect and freeze further plugs.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;

  // Access size code: number of bytes minus one
  typedef enum logic [1:0] {
    ACC_1B = 2'd0,
    ACC_2B = 2'd1,
    ACC_3B = 2'd2,
    ACC_4B = 2'd3
  } acc_size_e;

  localparam int unsigned LANES = 4;

  function automatic logic lane_in_size(acc_size_e sz, int unsigned lane);
    return lane <= 32'(sz);
  endfunction

endpackage

// File: rtl/cpm_bus_split.sv
module cpm_bus_split
  import cpu_presence_pkg::*;
#(
  parameter int MAP_BYTES = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [1:0]                   bus_size,
  input  logic [8*LANES-1:0]           bus_wdata,
  output logic                         rd_fire,
  output logic [LANES-1:0]             lane_en,
  output logic [LANES-1:0][ADDR_W-1:0] lane_off,
  output logic                         magic_wr
);

  acc_size_e          size_e;
  logic [LANES-1:0]   lane_zero;

  assign size_e = acc_size_e'(bus_size);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W:0] full_off;
    logic            in_win;
    assign full_off    = {1'b0, bus_addr} + (ADDR_W+1)'(k);
    assign in_win      = full_off < (ADDR_W+1)'(MAP_BYTES);
    assign lane_en[k]  = in_win && lane_in_size(size_e, k);
    assign lane_off[k] = full_off[ADDR_W-1:0];
    assign lane_zero[k] = lane_en[k] && (full_off == '0)
                          && (bus_wdata[8*k +: 8] == 8'h00);
  end

  assign rd_fire  = bus_req && !bus_we;
  assign magic_wr = bus_req && bus_we && (|lane_zero);

endmodule

// File: rtl/cpm_plug_ctrl.sv
module cpm_plug_ctrl #(
  parameter int PLUG_ID_W = 9,
  parameter int MAP_BYTES = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 plug_valid,
  input  logic [PLUG_ID_W-1:0] plug_id,
  input  logic                 magic_wr,
  output logic                 set_en,
  output logic [ADDR_W-1:0]    set_byte,
  output logic [2:0]           set_bit,
  output logic                 legacy_exit,
  output logic                 hp_event
);

  localparam int HI_W = PLUG_ID_W - 3;

  logic in_range;
  logic oor_plug;
  logic exit_q;
  logic ev_pend_q;
  logic ev_out_q;

  assign in_range = plug_id[PLUG_ID_W-1:3] < HI_W'(MAP_BYTES);
  assign set_en   = plug_valid && in_range && !exit_q;
  assign oor_plug = plug_valid && !in_range;
  assign set_byte = plug_id[3 +: ADDR_W];
  assign set_bit  = plug_id[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      exit_q    <= 1'b0;
      ev_pend_q <= 1'b0;
      ev_out_q  <= 1'b0;
    end else begin
      exit_q    <= exit_q || oor_plug || magic_wr;
      ev_pend_q <= set_en;
      ev_out_q  <= ev_pend_q;
    end
  end

  assign legacy_exit = exit_q;
  assign hp_event    = ev_out_q;

  a_r8_exit_sticky: assert property (@(posedge clk) disable iff (rst)
    legacy_exit |=> legacy_exit);

  a_r7_oor_exits: assert property (@(posedge clk) disable iff (rst)
    (plug_valid && plug_id[PLUG_ID_W-1:3] >= HI_W'(MAP_BYTES)) |=> legacy_exit);

  a_r5_magic_exits: assert property (@(posedge clk) disable iff (rst)
    magic_wr |=> legacy_exit);

  a_r8_no_set_after_exit: assert property (@(posedge clk) disable iff (rst)
    legacy_exit |-> !set_en);

endmodule

// File: rtl/cpm_map_store.sv
module cpm_map_store
  import cpu_presence_pkg::*;
#(
  parameter int MAP_BYTES = 32,
  parameter int ADDR_W    = 5,
  parameter logic [MAP_BYTES*8-1:0] INIT_MAP = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         set_en,
  input  logic [ADDR_W-1:0]            set_byte,
  input  logic [2:0]                   set_bit,
  input  logic                         rd_fire,
  input  logic [LANES-1:0]             lane_en,
  input  logic [LANES-1:0][ADDR_W-1:0] lane_off,
  output logic                         rvalid,
  output logic [8*LANES-1:0]           rdata
);

  localparam int MAP_BITS = MAP_BYTES * 8;

  logic [7:0]          map_q [MAP_BYTES];
  logic [MAP_BITS-1:0] map_flat;
  logic                rvalid_q;
  logic [8*LANES-1:0]  rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAP_BYTES; i++) map_q[i] <= INIT_MAP[8*i +: 8];
    end else if (set_en) begin
      map_q[set_byte][set_bit] <= 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) rdata_q[8*k +: 8] <= 8'h00;
      else if (rd_fire)
        rdata_q[8*k +: 8] <= lane_en[k] ? map_q[lane_off[k]] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= rd_fire;
  end

  always_comb begin
    for (int i = 0; i < MAP_BYTES; i++) map_flat[8*i +: 8] = map_q[i];
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;

  a_r2_bits_persist: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((map_flat & $past(map_flat)) == $past(map_flat)));

  a_r2_set_visible: assert property (@(posedge clk) disable iff (rst)
    set_en |=> map_flat[{$past(set_byte), $past(set_bit)}]);

  a_r4_rvalid_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rvalid);

  a_r4_no_rvalid_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> !rvalid);

endmodule

// File: rtl/cpu_presence_regs.sv
module cpu_presence_regs
  import cpu_presence_pkg::*;
#(
  parameter int MAP_BYTES = 32,
  parameter int PLUG_ID_W = 9,
  parameter logic [MAP_BYTES*8-1:0] INIT_MAP = (MAP_BYTES*8)'(32'h0000_000F)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         plug_valid,
  input  logic [PLUG_ID_W-1:0]         plug_id,
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [$clog2(MAP_BYTES)-1:0] bus_addr,
  input  logic [1:0]                   bus_size,
  input  logic [31:0]                  bus_wdata,
  output logic                         bus_rvalid,
  output logic [31:0]                  bus_rdata,
  output logic                         legacy_exit,
  output logic                         hp_event
);

  localparam int ADDR_W = $clog2(MAP_BYTES);

  logic                         rd_fire;
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][ADDR_W-1:0] lane_off;
  logic                         magic_wr;
  logic                         set_en;
  logic [ADDR_W-1:0]            set_byte;
  logic [2:0]                   set_bit;

  cpm_bus_split #(
    .MAP_BYTES (MAP_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_split (
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .rd_fire   (rd_fire),
    .lane_en   (lane_en),
    .lane_off  (lane_off),
    .magic_wr  (magic_wr)
  );

  cpm_plug_ctrl #(
    .PLUG_ID_W (PLUG_ID_W),
    .MAP_BYTES (MAP_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_plug (
    .clk         (clk),
    .rst         (rst),
    .plug_valid  (plug_valid),
    .plug_id     (plug_id),
    .magic_wr    (magic_wr),
    .set_en      (set_en),
    .set_byte    (set_byte),
    .set_bit     (set_bit),
    .legacy_exit (legacy_exit),
    .hp_event    (hp_event)
  );

  cpm_map_store #(
    .MAP_BYTES (MAP_BYTES),
    .ADDR_W    (ADDR_W),
    .INIT_MAP  (INIT_MAP)
  ) u_map (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_en),
    .set_byte (set_byte),
    .set_bit  (set_bit),
    .rd_fire  (rd_fire),
    .lane_en  (lane_en),
    .lane_off (lane_off),
    .rvalid   (bus_rvalid),
    .rdata    (bus_rdata)
  );

endmodule

// File: tb/tb_cpu_presence_regs.sv
module tb_cpu_presence_regs;

  localparam logic [255:0] TB_INIT = (256'h1 << 255) | (256'h1 << 100) | 256'h3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        plug_valid = 1'b0;
  logic [8:0]  plug_id = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        legacy_exit;
  logic        hp_event;

  logic [255:0] model;
  logic         exp_exit;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cpu_presence_regs #(
    .MAP_BYTES (32),
    .PLUG_ID_W (9),
    .INIT_MAP  (TB_INIT)
  ) dut (
    .clk (clk), .rst (rst),
    .plug_valid (plug_valid), .plug_id (plug_id),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_size (bus_size), .bus_wdata (bus_wdata),
    .bus_rvalid (bus_rvalid), .bus_rdata (bus_rdata),
    .legacy_exit (legacy_exit), .hp_event (hp_event)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int addr, input int size);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (k <= size && addr + k < 32) v[8*k +: 8] = model[8*(addr+k) +: 8];
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model = TB_INIT;
    exp_exit = 1'b0;
    @(negedge clk);
    chk(legacy_exit == 1'b0, "R1 exit", 32'(legacy_exit), 32'h0);
    chk(hp_event == 1'b0, "R1 event", 32'(hp_event), 32'h0);
    chk(bus_rvalid == 1'b0, "R1 rvalid", 32'(bus_rvalid), 32'h0);
  endtask

  task automatic do_read(input int addr, input int size, input string req);
    bus_req = 1'b1; bus_we = 1'b0;
    bus_addr = 5'(addr); bus_size = 2'(size);
    @(negedge clk);
    bus_req = 1'b0;
    chk(bus_rvalid == 1'b1, req, 32'(bus_rvalid), 32'h1);
    chk(bus_rdata == exp_read(addr, size), req, bus_rdata, exp_read(addr, size));
  endtask

  task automatic sweep_reads(input string req);
    for (int a = 0; a < 32; a++)
      for (int s = 0; s < 4; s++) do_read(a, s, req);
  endtask

  task automatic do_write(input int addr, input int size, input logic [31:0] d,
                          input logic magic, input string req);
    bus_req = 1'b1; bus_we = 1'b1;
    bus_addr = 5'(addr); bus_size = 2'(size); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    chk(bus_rvalid == 1'b0, "R4 no rvalid on write", 32'(bus_rvalid), 32'h0);
    if (magic) exp_exit = 1'b1;
    chk(legacy_exit == exp_exit, req, 32'(legacy_exit), 32'(exp_exit));
  endtask

  task automatic do_plug(input int id, input string req);
    logic acc;
    acc = (id < 256) && !exp_exit;
    plug_valid = 1'b1; plug_id = 9'(id);
    @(negedge clk);
    plug_valid = 1'b0;
    if (acc) model[id] = 1'b1;
    if (id >= 256) exp_exit = 1'b1;
    chk(legacy_exit == exp_exit, {req, " exit"}, 32'(legacy_exit), 32'(exp_exit));
    chk(hp_event == 1'b0, {req, " event early"}, 32'(hp_event), 32'h0);
    @(negedge clk);
    chk(hp_event == acc, {req, " R3 event"}, 32'(hp_event), 32'(acc));
    @(negedge clk);
    chk(hp_event == 1'b0, {req, " R3 event width"}, 32'(hp_event), 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model = TB_INIT;
    exp_exit = 1'b0;
    do_reset();
    sweep_reads("R1 R4 reset map");

    // R6: writes that must be ignored
    for (int s = 0; s < 4; s++) do_write(0, s, 32'h0000_00A5 << s, 1'b0, "R6 nonzero at 0");
    for (int a = 1; a < 32; a++) do_write(a, 0, 32'h0, 1'b0, "R6 zero elsewhere");
    do_write(28, 3, 32'h0, 1'b0, "R6 wide zero high");
    sweep_reads("R6 map unchanged");

    // R2/R3: plug every id in a scattered order
    for (int i = 0; i < 256; i++) do_plug((i * 37 + 11) % 256, "R2 plug");
    sweep_reads("R2 map after plugs");

    // R9: plug and read of the same byte in one cycle
    do_reset();
    plug_valid = 1'b1; plug_id = 9'd9;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 5'd1; bus_size = 2'd0;
    @(negedge clk);
    plug_valid = 1'b0; bus_req = 1'b0;
    chk(bus_rdata == exp_read(1, 0), "R9 old value", bus_rdata, exp_read(1, 0));
    model[9] = 1'b1;
    do_read(1, 0, "R9 new value");
    chk(hp_event == 1'b1, "R3 event after collision", 32'(hp_event), 32'h1);
    @(negedge clk);

    // R5 wide magic write, then R8 freeze
    do_reset();
    do_write(0, 3, 32'hA5A5_A500, 1'b1, "R5 wide magic");
    do_plug(20, "R8 plug after exit");
    do_plug(255, "R8 replug after exit");
    sweep_reads("R8 map frozen");
    repeat (3) @(negedge clk);
    chk(legacy_exit == 1'b1, "R8 sticky", 32'(legacy_exit), 32'h1);

    // R5 byte magic write
    do_reset();
    do_write(0, 0, 32'hFFFF_FF00, 1'b1, "R5 byte magic");

    // R7 out-of-range plugs
    do_reset();
    do_plug(256, "R7 id 256");
    sweep_reads("R7 map untouched");
    do_reset();
    do_plug(511, "R7 id 511");
    do_plug(40, "R8 after oor");
    do_read(5, 0, "R7 R8 byte 5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule